// File: doc/BRIEF.md
# Leveled Interrupt Controller with Non-Maskable Watchdog Request

This block gathers interrupt events from five peripheral sources (programmable timer, input port, serial interface, stopwatch timer, clock timer) and one watchdog line. It offers the CPU at most one request at a time, together with that request's priority level and vector number. Each maskable source has a sticky event flag, an enable bit and a 2-bit priority level, all reached through a small byte-wide register bus. The controller also holds the CPU's current 2-bit mask level. A request gets through only when its level is strictly above that mask.

The flags record every event whatever the enable, level and mask settings are, so software can poll them. A flag is cleared only by writing a one to its bit. When the CPU acknowledges a request, the mask is raised to the level just accepted and stays there until software writes it again. The flag of the accepted source is left set.

A rising edge on the watchdog line creates a non-maskable request. That request is held until it is acknowledged, beats every peripheral request, and on acknowledge sets the mask to its highest value.

Top module: `irq_level_ctrl`

## Requirements
- R1: An event pulse on `src_evt[i]` sets flag i (bit i at bus address 0) one clock later, whatever the enable bit, level and mask are.
- R2: Writing address 0 clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged. If an event and a clearing write hit the same bit in the same cycle, the flag ends up set.
- R3: A source whose enable bit (address 1, bit i) is 0, or whose level is 0, raises no request even when its flag is set. Levels are bits [2i+1:2i] of the 16-bit word formed by address 3 (high byte) and address 2 (low byte).
- R4: A peripheral request is presented only when its level is strictly greater than the mask (bits [5:4] of address 3). A blocked request appears as soon as the mask is lowered below its level, provided its flag is still set.
- R5: Among the eligible sources, the highest level wins. On equal levels the lower source index wins, in this order: 0 programmable timer, 1 input port, 2 serial, 3 stopwatch, 4 clock.
- R6: The vector of peripheral source i is 8'h26 + 2*i and `irq_level` is its level. With no request, `irq_req`, `irq_level` and `irq_vector` are 0. The values 8'h24 and 8'h25 are never presented.
- R7: When `irq_ack` is high while `irq_req` is high, the mask is loaded with `irq_level` at the next edge, and the accepted source's flag stays set.
- R8: A rising edge of `wdt_evt` produces exactly one non-maskable request, held until acknowledged. It is presented one clock after the edge with `irq_nmi`=1, level 3 and vector 8'h04, whatever the mask and the other requests are. Its acknowledge sets the mask to 3. A `wdt_evt` level that stays high produces no further request.
- R9: After reset, all flags, enables, levels and the mask read 0, and no request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_evt | input | 5 | One-cycle event pulses from the five peripheral sources |
| wdt_evt | input | 1 | Watchdog event line, edge-detected |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` (combinational) |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | A request is presented |
| irq_nmi | output | 1 | The presented request is the non-maskable one |
| irq_level | output | 2 | Level of the presented request |
| irq_vector | output | 8 | Vector number of the presented request |

## Verification
The bench writes the clearing pattern zero and checks the flag survives. A design that treats a zero data bit as a clear would lose the flag. It fires an event in the same cycle as its own clear and expects the flag to stay set. It places a request at a level equal to the mask, where a design using greater-or-equal would wrongly accept it. It also sets up equal-level ties across all five sources, which catches a wrong fixed order. After an acknowledge it reads back the mask and the flag, which exposes a design that clears the flag or leaves the mask alone. It holds the watchdog line high across an NMI acknowledge to catch a level-sensitive design that would raise a second NMI. Finally it fires the watchdog over a pending peripheral request to confirm the non-maskable request wins.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 5;
  localparam int LVL_W    = 2;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int VEC_W    = 8;
  // bit position of the mask field inside the 16-bit level word
  localparam int MASK_POS = 12;

  localparam logic [ADDR_W-1:0] ADR_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_LVLA = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_LVLB = 2'd3;

  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank
  import irq_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int LW    = LVL_W,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [N_SRC-1:0]  flags_q,
  output logic [N_SRC-1:0]  en_q,
  output logic [N_SRC*LW-1:0] lvl_q
);
  logic [N_SRC-1:0]    flags_n;
  logic [N_SRC-1:0]    en_n;
  logic [N_SRC*LW-1:0] lvl_n;
  logic                wr_flag;
  logic                wr_en;

  assign wr_flag = bus_we && (bus_addr == ADR_FLAG);
  assign wr_en   = bus_we && (bus_addr == ADR_EN);

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_src
      localparam int BITPOS = gi * LW;
      localparam int BYTE   = BITPOS / DW;
      localparam int OFS    = BITPOS % DW;
      logic wr_lvl;
      assign wr_lvl = bus_we && (bus_addr == AW'(32'(ADR_LVLA) + BYTE));

      // event set has priority over write-one clear
      always_comb begin
        flags_n[gi] = flags_q[gi];
        if (wr_flag && bus_wdata[gi])
          flags_n[gi] = 1'b0;
        if (src_evt[gi])
          flags_n[gi] = 1'b1;
      end

      always_comb begin
        en_n[gi] = en_q[gi];
        if (wr_en)
          en_n[gi] = bus_wdata[gi];
      end

      always_comb begin
        lvl_n[BITPOS +: LW] = lvl_q[BITPOS +: LW];
        if (wr_lvl)
          lvl_n[BITPOS +: LW] = bus_wdata[OFS +: LW];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      lvl_q   <= '0;
    end else begin
      flags_q <= flags_n;
      en_q    <= en_n;
      lvl_q   <= lvl_n;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int LW    = LVL_W,
  localparam int IW   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]    flags,
  input  logic [N_SRC-1:0]    en,
  input  logic [N_SRC*LW-1:0] lvl,
  input  logic [LW-1:0]       mask,
  output logic                found,
  output logic [IW-1:0]       win_idx,
  output logic [LW-1:0]       win_lvl
);
  logic [LW-1:0]    lvl_arr [N_SRC];
  logic [N_SRC-1:0] elig;

  genvar gi;
  generate
    for (gi = 0; gi < N_SRC; gi++) begin : g_elig
      assign lvl_arr[gi] = lvl[gi*LW +: LW];
      // strictly above mask implies nonzero level
      assign elig[gi]    = flags[gi] && en[gi] && (lvl[gi*LW +: LW] > mask);
    end
  endgenerate

  // scan in fixed order; strict compare keeps the lower index on a tie
  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (lvl_arr[i] > win_lvl)) begin
        win_lvl = lvl_arr[i];
        win_idx = IW'(i);
      end
    end
    found = |elig;
  end
endmodule

// File: rtl/irq_nmi_edge.sv
module irq_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_evt,
  input  logic ack_nmi,
  output logic nmi_pend
);
  logic wdt_q;
  logic rise;
  logic pend_n;

  assign rise = wdt_evt && !wdt_q;

  always_comb begin
    pend_n = nmi_pend;
    if (ack_nmi)
      pend_n = 1'b0;
    if (rise)
      pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdt_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      wdt_q    <= wdt_evt;
      nmi_pend <= pend_n;
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int                N_SRC    = NUM_SRC,
  parameter int                LW       = LVL_W,
  parameter int                DW       = DATA_W,
  parameter int                AW       = ADDR_W,
  parameter int                VW       = VEC_W,
  parameter logic [VEC_W-1:0]  VEC_BASE = 8'h26,
  parameter logic [VEC_W-1:0]  NMI_VEC  = 8'h04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_evt,
  input  logic             wdt_evt,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic             irq_ack,
  output logic             irq_req,
  output logic             irq_nmi,
  output logic [LW-1:0]    irq_level,
  output logic [VW-1:0]    irq_vector
);
  localparam int IW     = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int WORD_W = 2 * DW;
  localparam int MOFS   = MASK_POS - DW;

  logic [N_SRC-1:0]    flags_q;
  logic [N_SRC-1:0]    en_q;
  logic [N_SRC*LW-1:0] lvl_q;
  logic [LW-1:0]       mask_q;
  logic [LW-1:0]       mask_n;
  logic                per_found;
  logic [IW-1:0]       per_idx;
  logic [LW-1:0]       per_lvl;
  logic                nmi_pend;
  logic                ack_take;
  logic                wr_mask;
  logic [WORD_W-1:0]   lvl_word;

  irq_src_bank #(.N_SRC(N_SRC), .LW(LW), .DW(DW), .AW(AW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_evt  (src_evt),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .flags_q  (flags_q),
    .en_q     (en_q),
    .lvl_q    (lvl_q)
  );

  irq_arbiter #(.N_SRC(N_SRC), .LW(LW)) u_arb (
    .flags  (flags_q),
    .en     (en_q),
    .lvl    (lvl_q),
    .mask   (mask_q),
    .found  (per_found),
    .win_idx(per_idx),
    .win_lvl(per_lvl)
  );

  irq_nmi_edge u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdt_evt (wdt_evt),
    .ack_nmi (irq_ack && nmi_pend),
    .nmi_pend(nmi_pend)
  );

  // presented request
  always_comb begin
    irq_req    = 1'b0;
    irq_nmi    = 1'b0;
    irq_level  = '0;
    irq_vector = '0;
    if (nmi_pend) begin
      irq_req    = 1'b1;
      irq_nmi    = 1'b1;
      irq_level  = '1;
      irq_vector = NMI_VEC;
    end else if (per_found) begin
      irq_req    = 1'b1;
      irq_level  = per_lvl;
      irq_vector = VEC_BASE + VW'({per_idx, 1'b0});
    end
  end

  // mask: acknowledge has priority over a bus write
  assign ack_take = irq_ack && irq_req;
  assign wr_mask  = bus_we && (bus_addr == ADR_LVLB);

  always_comb begin
    mask_n = mask_q;
    if (ack_take)
      mask_n = irq_level;
    else if (wr_mask)
      mask_n = bus_wdata[MOFS +: LW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else
      mask_q <= mask_n;
  end

  // read back
  always_comb begin
    lvl_word = '0;
    lvl_word[N_SRC*LW-1:0] = lvl_q;
    lvl_word[MASK_POS +: LW] = mask_q;
  end

  always_comb begin
    case (bus_addr)
      ADR_FLAG: bus_rdata = DW'(flags_q);
      ADR_EN:   bus_rdata = DW'(en_q);
      ADR_LVLA: bus_rdata = lvl_word[DW-1:0];
      default:  bus_rdata = lvl_word[WORD_W-1:DW];
    endcase
  end
endmodule

// File: rtl/irq_level_chk.sv
module irq_level_chk
  import irq_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int LW    = LVL_W,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W,
  parameter int VW    = VEC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic             irq_nmi,
  input logic [LW-1:0]    irq_level,
  input logic [VW-1:0]    irq_vector,
  input logic             irq_ack,
  input logic             wdt_evt,
  input logic             bus_we,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_wdata,
  input logic [N_SRC-1:0] flags_q,
  input logic [LW-1:0]    mask_q
);
  logic [N_SRC-1:0] keep;
  assign keep = (bus_we && bus_addr == ADR_FLAG) ? (flags_q & ~bus_wdata[N_SRC-1:0]) : flags_q;

  // R2: flags not written with one remain set
  p_flag_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(keep)) == $past(keep)));

  // R4: a presented peripheral request is above the mask
  p_above_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_nmi) |-> (irq_level > mask_q));

  // R6: reserved vector slots never appear
  p_no_reserved_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vector != 8'h24 && irq_vector != 8'h25));

  // R7: accepted level becomes the mask
  p_ack_loads_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> (mask_q == $past(irq_level)));

  // R8: watchdog edge yields a non-maskable request
  p_nmi_after_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_evt) |=> (irq_req && irq_nmi && irq_vector == 8'h04));

  // R9: nothing presented when idle state has no flags and no nmi
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0 && !irq_nmi) |-> !irq_req);
endmodule

bind irq_level_ctrl irq_level_chk #(
  .N_SRC(N_SRC), .LW(LW), .DW(DW), .AW(AW), .VW(VW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .irq_nmi   (irq_nmi),
  .irq_level (irq_level),
  .irq_vector(irq_vector),
  .irq_ack   (irq_ack),
  .wdt_evt   (wdt_evt),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .flags_q   (flags_q),
  .mask_q    (mask_q)
);

// File: tb/test_irq_level_ctrl.sv
module test_irq_level_ctrl;
  logic       clk;
  logic       rst_n;
  logic [4:0] src_evt;
  logic       wdt_evt;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_ack;
  logic       irq_req;
  logic       irq_nmi;
  logic [1:0] irq_level;
  logic [7:0] irq_vector;

  int total = 0;
  int bad   = 0;

  irq_level_ctrl i_irq_level_ctrl (
    .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wdt_evt(wdt_evt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_ack(irq_ack), .irq_req(irq_req),
    .irq_nmi(irq_nmi), .irq_level(irq_level), .irq_vector(irq_vector)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {evt, en, levels[9:0], mask, exp_req, exp_lvl, exp_vec}
  localparam logic [32:0] TBL [8] = '{
    {5'b00001, 5'b00001, 10'h001, 2'd0, 1'b1, 2'd1, 8'h26},
    {5'b11111, 5'b11111, 10'h2AA, 2'd0, 1'b1, 2'd2, 8'h26},
    {5'b11110, 5'b11111, 10'h2F4, 2'd0, 1'b1, 2'd3, 8'h2A},
    {5'b10000, 5'b10000, 10'h300, 2'd2, 1'b1, 2'd3, 8'h2E},
    {5'b10000, 5'b10000, 10'h200, 2'd2, 1'b0, 2'd0, 8'h00},
    {5'b00100, 5'b00000, 10'h030, 2'd0, 1'b0, 2'd0, 8'h00},
    {5'b01000, 5'b01000, 10'h000, 2'd0, 1'b0, 2'd0, 8'h00},
    {5'b00011, 5'b00011, 10'h009, 2'd0, 1'b1, 2'd2, 8'h28}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #2;
    d = bus_rdata;
  endtask

  task automatic pulse_evt(input logic [4:0] e);
    @(negedge clk);
    src_evt = e;
    @(negedge clk);
    src_evt = '0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; src_evt = '0; wdt_evt = 1'b0; bus_we = 1'b0;
    bus_addr = '0; bus_wdata = '0; irq_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R9 reset register", 32'(d), 32'h0);
    end
    check("R9 reset req", 32'(irq_req), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R3 R4 R5 R6
    foreach (TBL[k]) begin
      logic [32:0] v;
      v = TBL[k];
      wr(2'd0, 8'h1F);
      wr(2'd1, {3'b000, v[27:23]});
      wr(2'd2, v[20:13]);
      wr(2'd3, {2'b00, v[12:11], 2'b00, v[22:21]});
      pulse_evt(v[32:28]);
      check("R3 R4 R5 table req", 32'(irq_req), 32'(v[10]));
      check("R5 table level", 32'(irq_level), 32'(v[9:8]));
      check("R6 table vector", 32'(irq_vector), 32'(v[7:0]));
      rd(2'd0, d);
      check("R1 table flags", 32'(d), 32'(v[32:28]));
    end

    // R1 R2 flag behaviour with enables off
    wr(2'd0, 8'h1F);
    wr(2'd1, 8'h00);
    pulse_evt(5'b00010);
    rd(2'd0, d); check("R1 flag set while disabled", 32'(d), 32'h02);
    check("R3 no request while disabled", 32'(irq_req), 32'h0);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R2 write zero keeps flag", 32'(d), 32'h02);
    wr(2'd0, 8'h02);
    rd(2'd0, d); check("R2 write one clears", 32'(d), 32'h00);
    @(negedge clk);
    src_evt = 5'b00010; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h02;
    @(negedge clk);
    src_evt = '0; bus_we = 1'b0;
    rd(2'd0, d); check("R2 set beats clear", 32'(d), 32'h02);
    wr(2'd0, 8'h1F);

    // R4 pending under mask, R7 acknowledge
    wr(2'd1, 8'h01);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h20);
    pulse_evt(5'b00001);
    check("R4 blocked at equal mask", 32'(irq_req), 32'h0);
    wr(2'd3, 8'h10);
    check("R4 released by lower mask", 32'(irq_req), 32'h1);
    check("R6 vector src0", 32'(irq_vector), 32'h26);
    pulse_ack();
    check("R7 request gone after ack", 32'(irq_req), 32'h0);
    rd(2'd3, d); check("R7 mask raised", 32'(d), 32'h20);
    rd(2'd0, d); check("R7 flag kept", 32'(d), 32'h01);

    // R8 non-maskable request
    wr(2'd3, 8'h30);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk);
    check("R8 nmi req", 32'(irq_req), 32'h1);
    check("R8 nmi flag", 32'(irq_nmi), 32'h1);
    check("R8 nmi level", 32'(irq_level), 32'h3);
    check("R8 nmi vector", 32'(irq_vector), 32'h04);
    pulse_ack();
    check("R8 nmi cleared by ack", 32'(irq_req), 32'h0);
    repeat (3) @(negedge clk);
    check("R8 held line no second nmi", 32'(irq_req), 32'h0);
    wdt_evt = 1'b0;
    wr(2'd3, 8'h00);
    check("R4 peripheral after mask cleared", 32'(irq_vector), 32'h26);
    @(negedge clk); wdt_evt = 1'b1;
    @(negedge clk);
    check("R8 nmi beats peripheral", 32'(irq_vector), 32'h04);
    pulse_ack();
    rd(2'd3, d); check("R8 mask three after nmi", 32'(d), 32'h30);
    check("R8 peripheral blocked after nmi", 32'(irq_req), 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule